// File: doc/BRIEF.md
# USB Endpoint Zero-Length Termination Logic

This block lives inside the endpoint engine of a USB device controller. It decides when the current transfer descriptor is finished. A descriptor is loaded with a total byte count, a direction, the endpoint's transfer type, the maximum packet size and a per-endpoint bit that turns zero-length termination off. From then on the block is told each time a packet completes and how long that packet was. It keeps the remaining byte count, which falls by each packet's length and stops at zero.

On transmit, zero-length termination covers one case. When the packet that drains the count is exactly the maximum size and termination is enabled, the block requests one extra empty packet. It retires the descriptor only after that empty packet has gone out.

On receive, a short packet always ends the descriptor. When a full-size packet drains the count and termination is enabled, the descriptor stays open until the host sends an empty packet. Isochronous endpoints never use the zero-length rule. The rule is applied to each descriptor separately, never to a logical transfer that spans several descriptors.

Top module: `usb_zlp_retire`

## Requirements
- R1: After reset, `active`, `retire`, `sendZlp` and `overflowErr` are all 0.
- R2: In idle, a `descLoad` pulse opens a descriptor and `active` rises in the next cycle. A `descLoad` while a descriptor is open is ignored, and the open descriptor keeps its original byte count.
- R3: Each packet-complete event lowers the remaining count by `pktLen`. The count saturates at zero and never grows except at a load.
- R4: Transmit (`dirTx`=1) with termination enabled (`zltDisable`=0, non-isochronous): when a packet of exactly `maxPktSize` brings the count to zero, `sendZlp` is 1 in the cycle after that event and `retire` stays 0. `retire` is 1 in the cycle after the next packet-complete event.
- R5: Transmit: when a packet shorter than `maxPktSize` brings the count to zero, `retire` is 1 in the following cycle and no `sendZlp` is raised.
- R6: Transmit with `zltDisable`=1: `sendZlp` never rises, and the descriptor retires in the cycle after the count reaches zero.
- R7: Receive (`dirTx`=0): any packet shorter than `maxPktSize`, including a zero-length one, retires the descriptor in the next cycle. This holds whatever the termination setting and whatever count remains.
- R8: Receive with termination enabled: when a full-size packet brings the count to zero, the descriptor stays active with no retire. The next packet-complete event retires it.
- R9: Receive with `zltDisable`=1: the descriptor retires in the cycle after the count reaches zero, even on a full-size packet.
- R10: With `xferType`=2'b01 (isochronous), `zltDisable` is ignored and the block behaves as if termination were disabled, in both directions. Types 2'b00, 2'b10 and 2'b11 honour the bit.
- R11: `retire` and `sendZlp` are each one clock wide. `retire` is followed by `active`=0, and the next load is accepted. A packet-complete event while idle has no effect.
- R12: On receive, a packet longer than the remaining count sets `overflowErr`. The flag stays set until the next accepted `descLoad` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descLoad | input | 1 | Pulse: open a new descriptor with the values below |
| descBytes | input | COUNT_W | Total byte count of the descriptor |
| dirTx | input | 1 | 1 = transmit (IN), 0 = receive (OUT) |
| zltDisable | input | 1 | 1 = zero-length termination off for this endpoint |
| xferType | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| maxPktSize | input | LEN_W | Endpoint maximum packet length in bytes |
| pktDone | input | 1 | Pulse: one packet sent or received |
| pktLen | input | LEN_W | Length of the packet flagged by pktDone |
| sendZlp | output | 1 | One-cycle request to transmit an empty packet |
| retire | output | 1 | One-cycle descriptor retire pulse |
| active | output | 1 | A descriptor is open |
| overflowErr | output | 1 | Received data exceeded the descriptor count |

## Verification
Most state faults in this block show up one cycle after a packet-complete event. A wrong remaining count or a wrong latched termination setting moves the retire pulse to an earlier or later packet. It can also turn a retire into a zero-length request, or the reverse. A stuck state shows as `active` that never falls, or as a second pulse in the cycle after the first. The directed cases count packets up to each boundary, so a count that is off by one packet is seen at the packet where the retire was expected.

// File: rtl/usb_zlp_pkg.sv
package usb_zlp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TXZ,
    ST_RXZ
  } zlpState_e;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic consume;
    logic flagOvf;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic isShort;
    logic hitsZero;
    logic overRun;
    logic zltEn;
    logic dirTx;
  } dpStatus_t;

  localparam logic [1:0] XFER_ISO = 2'b01;

endpackage

// File: rtl/usb_zlp_datapath.sv
module usb_zlp_datapath
  import usb_zlp_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int LEN_W   = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [COUNT_W-1:0] descBytes,
  input  logic               dirTx,
  input  logic               zltDisable,
  input  logic [1:0]         xferType,
  input  logic [LEN_W-1:0]   maxPktSize,
  input  logic [LEN_W-1:0]   pktLen,
  output dpStatus_t          status,
  output logic               overflowErr
);

  localparam logic [COUNT_W-1:0] ZERO_COUNT = '0;

  logic [COUNT_W-1:0] remaining;
  logic [LEN_W-1:0]   maxPktQ;
  logic               dirTxQ;
  logic               zltEnQ;
  logic               ovfQ;

  logic [COUNT_W-1:0] lenExt;
  logic [COUNT_W-1:0] nextRemain;
  logic               overRun;

  always_comb begin
    lenExt     = COUNT_W'(pktLen);
    overRun    = lenExt > remaining;
    nextRemain = overRun ? ZERO_COUNT : (remaining - lenExt);
  end

  always_comb begin
    status.isShort  = pktLen < maxPktQ;
    status.hitsZero = nextRemain == ZERO_COUNT;
    status.overRun  = overRun;
    status.zltEn    = zltEnQ;
    status.dirTx    = dirTxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      maxPktQ   <= '0;
      dirTxQ    <= 1'b0;
      zltEnQ    <= 1'b0;
      ovfQ      <= 1'b0;
    end else if (strobe.load) begin
      remaining <= descBytes;
      maxPktQ   <= maxPktSize;
      dirTxQ    <= dirTx;
      zltEnQ    <= !zltDisable && (xferType != XFER_ISO);
      ovfQ      <= 1'b0;
    end else begin
      if (strobe.consume) remaining <= nextRemain;
      if (strobe.flagOvf) ovfQ <= 1'b1;
    end
  end

  assign overflowErr = ovfQ;

  // R3: outside a load the count can only stay or fall
  assert_count_no_growth_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> remaining <= $past(remaining));

  // R12: error flag stays until a load
  assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !strobe.load) |=> ovfQ);

endmodule

// File: rtl/usb_zlp_ctrl.sv
module usb_zlp_ctrl
  import usb_zlp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      descLoad,
  input  logic      pktDone,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      sendZlp,
  output logic      retire,
  output logic      active
);

  zlpState_e state, nextState;
  logic      retireD;
  logic      zlpD;

  always_comb begin
    nextState      = state;
    strobe         = '0;
    retireD        = 1'b0;
    zlpD           = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (descLoad) begin
          strobe.load = 1'b1;
          nextState   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (pktDone) begin
          strobe.consume = 1'b1;
          if (status.dirTx) begin
            if (status.hitsZero) begin
              if (!status.isShort && status.zltEn) begin
                zlpD      = 1'b1;
                nextState = ST_TXZ;
              end else begin
                retireD   = 1'b1;
                nextState = ST_IDLE;
              end
            end
          end else begin
            strobe.flagOvf = status.overRun;
            if (status.isShort) begin
              retireD   = 1'b1;
              nextState = ST_IDLE;
            end else if (status.hitsZero) begin
              if (status.zltEn) begin
                nextState = ST_RXZ;
              end else begin
                retireD   = 1'b1;
                nextState = ST_IDLE;
              end
            end
          end
        end
      end
      ST_TXZ: begin
        if (pktDone) begin
          strobe.consume = 1'b1;
          retireD        = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      ST_RXZ: begin
        if (pktDone) begin
          strobe.consume = 1'b1;
          strobe.flagOvf = status.overRun;
          retireD        = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      retire  <= 1'b0;
      sendZlp <= 1'b0;
    end else begin
      state   <= nextState;
      retire  <= retireD;
      sendZlp <= zlpD;
    end
  end

  assign active = state != ST_IDLE;

  assert_retire_one_wide_R11: assert property (@(posedge clk) disable iff (!rstN)
    retire |=> !retire);

  assert_zlp_one_wide_R11: assert property (@(posedge clk) disable iff (!rstN)
    sendZlp |=> !sendZlp);

  assert_retire_after_pkt_R11: assert property (@(posedge clk) disable iff (!rstN)
    retire |-> $past(pktDone));

  // R4/R6/R10: an empty packet is requested only for transmit with the rule on
  assert_zlp_needs_tx_en_R4: assert property (@(posedge clk) disable iff (!rstN)
    sendZlp |-> (status.dirTx && status.zltEn));

  assert_no_zlp_and_retire_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(sendZlp && retire));

endmodule

// File: rtl/usb_zlp_retire.sv
module usb_zlp_retire
  import usb_zlp_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int LEN_W   = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               descLoad,
  input  logic [COUNT_W-1:0] descBytes,
  input  logic               dirTx,
  input  logic               zltDisable,
  input  logic [1:0]         xferType,
  input  logic [LEN_W-1:0]   maxPktSize,
  input  logic               pktDone,
  input  logic [LEN_W-1:0]   pktLen,
  output logic               sendZlp,
  output logic               retire,
  output logic               active,
  output logic               overflowErr
);

  dpStrobe_t strobe;
  dpStatus_t status;

  usb_zlp_datapath #(.COUNT_W(COUNT_W), .LEN_W(LEN_W)) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .descBytes  (descBytes),
    .dirTx      (dirTx),
    .zltDisable (zltDisable),
    .xferType   (xferType),
    .maxPktSize (maxPktSize),
    .pktLen     (pktLen),
    .status     (status),
    .overflowErr(overflowErr)
  );

  usb_zlp_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .descLoad(descLoad),
    .pktDone (pktDone),
    .status  (status),
    .strobe  (strobe),
    .sendZlp (sendZlp),
    .retire  (retire),
    .active  (active)
  );

  // R11: after a retire the block is idle
  assert_idle_after_retire_R11: assert property (@(posedge clk) disable iff (!rstN)
    retire |-> !active);

endmodule

// File: tb/tb_usb_zlp_retire.sv
`timescale 1ns/1ps
module tb_usb_zlp_retire;

  localparam int COUNT_W = 16;
  localparam int LEN_W   = 11;
  localparam int WD_CYCLES = 20000;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               descLoad = 1'b0;
  logic [COUNT_W-1:0] descBytes = '0;
  logic               dirTx = 1'b0;
  logic               zltDisable = 1'b0;
  logic [1:0]         xferType = 2'b10;
  logic [LEN_W-1:0]   maxPktSize = 11'd64;
  logic               pktDone = 1'b0;
  logic [LEN_W-1:0]   pktLen = '0;
  logic               sendZlp, retire, active, overflowErr;

  int  nTests = 0;
  int  nFail  = 0;
  bit  finished = 1'b0;
  logic gotRet, gotZlp;

  always #4 clk = ~clk;

  usb_zlp_retire #(.COUNT_W(COUNT_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .descLoad(descLoad), .descBytes(descBytes),
    .dirTx(dirTx), .zltDisable(zltDisable), .xferType(xferType),
    .maxPktSize(maxPktSize), .pktDone(pktDone), .pktLen(pktLen),
    .sendZlp(sendZlp), .retire(retire), .active(active), .overflowErr(overflowErr)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic loadDesc(input int bytes, input logic tx, input logic dis, input logic [1:0] typ);
    @(negedge clk);
    descLoad = 1'b1; descBytes = COUNT_W'(bytes); dirTx = tx;
    zltDisable = dis; xferType = typ;
    @(negedge clk);
    descLoad = 1'b0;
  endtask

  // drive one packet-complete; outputs sampled in the cycle after the edge
  task automatic sendPkt(input int len);
    @(negedge clk);
    pktDone = 1'b1; pktLen = LEN_W'(len);
    @(negedge clk);
    pktDone = 1'b0;
    gotRet = retire; gotZlp = sendZlp;
  endtask

  task automatic tReset;
    check("R1 active", active, 1'b0);
    check("R1 retire", retire, 1'b0);
    check("R1 sendZlp", sendZlp, 1'b0);
    check("R1 overflowErr", overflowErr, 1'b0);
  endtask

  task automatic tTxZlp;
    loadDesc(128, 1'b1, 1'b0, 2'b10);
    check("R2 active after load", active, 1'b1);
    sendPkt(64);
    check("R4 no retire mid", gotRet, 1'b0);
    sendPkt(64);
    check("R4 zlp requested", gotZlp, 1'b1);
    check("R4 no retire with zlp", gotRet, 1'b0);
    @(negedge clk);
    check("R11 zlp one wide", sendZlp, 1'b0);
    check("R4 still active", active, 1'b1);
    sendPkt(0);
    check("R4 retire after zlp", gotRet, 1'b1);
    check("R11 idle after retire", active, 1'b0);
    @(negedge clk);
    check("R11 retire one wide", retire, 1'b0);
  endtask

  task automatic tTxShort;
    loadDesc(100, 1'b1, 1'b0, 2'b00);
    sendPkt(64);
    check("R5 not yet", gotRet, 1'b0);
    sendPkt(36);
    check("R5 short retire", gotRet, 1'b1);
    check("R5 no zlp", gotZlp, 1'b0);
  endtask

  task automatic tTxDisabled;
    loadDesc(128, 1'b1, 1'b1, 2'b10);
    sendPkt(64);
    sendPkt(64);
    check("R6 retire at zero", gotRet, 1'b1);
    check("R6 no zlp", gotZlp, 1'b0);
  endtask

  task automatic tRxShort;
    loadDesc(200, 1'b0, 1'b0, 2'b10);
    sendPkt(64);
    check("R7 full pkt keeps open", gotRet, 1'b0);
    sendPkt(10);
    check("R7 short retire", gotRet, 1'b1);
    loadDesc(200, 1'b0, 1'b1, 2'b11);
    sendPkt(0);
    check("R7 empty pkt retire", gotRet, 1'b1);
  endtask

  task automatic tRxWait;
    loadDesc(128, 1'b0, 1'b0, 2'b10);
    sendPkt(64);
    sendPkt(64);
    check("R8 waits for zlp", gotRet, 1'b0);
    @(negedge clk);
    check("R8 still active", active, 1'b1);
    sendPkt(0);
    check("R8 retire on zlp", gotRet, 1'b1);
    check("R12 no overflow", overflowErr, 1'b0);
  endtask

  task automatic tRxDisabled;
    loadDesc(128, 1'b0, 1'b1, 2'b10);
    sendPkt(64);
    sendPkt(64);
    check("R9 retire at zero", gotRet, 1'b1);
  endtask

  task automatic tIso;
    loadDesc(128, 1'b1, 1'b0, 2'b01);
    sendPkt(64);
    sendPkt(64);
    check("R10 tx iso retire", gotRet, 1'b1);
    check("R10 tx iso no zlp", gotZlp, 1'b0);
    loadDesc(128, 1'b0, 1'b0, 2'b01);
    sendPkt(64);
    sendPkt(64);
    check("R10 rx iso retire", gotRet, 1'b1);
  endtask

  task automatic tLoadIgnored;
    loadDesc(64, 1'b1, 1'b1, 2'b10);
    loadDesc(500, 1'b1, 1'b1, 2'b10);
    sendPkt(64);
    check("R2 second load ignored", gotRet, 1'b1);
    check("R3 count drained", active, 1'b0);
  endtask

  task automatic tIdlePkt;
    sendPkt(64);
    check("R11 idle pkt no retire", gotRet, 1'b0);
    check("R11 idle pkt no zlp", gotZlp, 1'b0);
    check("R11 idle stays idle", active, 1'b0);
  endtask

  task automatic tOverflow;
    loadDesc(50, 1'b0, 1'b0, 2'b10);
    sendPkt(64);
    check("R12 overflow set", overflowErr, 1'b1);
    check("R3 saturated, waits zlp", gotRet, 1'b0);
    sendPkt(0);
    check("R12 retire", gotRet, 1'b1);
    check("R12 flag held", overflowErr, 1'b1);
    loadDesc(64, 1'b0, 1'b0, 2'b10);
    check("R12 cleared by load", overflowErr, 1'b0);
    sendPkt(10);
    check("R7 retire after reload", gotRet, 1'b1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTxZlp();
    tTxShort();
    tTxDisabled();
    tRxShort();
    tRxWait();
    tRxDisabled();
    tIso();
    tLoadIgnored();
    tIdlePkt();
    tOverflow();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule